// File: doc/BRIEF.md
# Step and Direction Pulse Generator

This block turns a signed velocity, written by a host, into a step pulse train and a direction level for one motor axis. Each clock the magnitude of the velocity is added to a phase accumulator. Every carry out of the accumulator asks for one step. A sequencer then issues the step while enforcing three minimum times: step high time, low space between steps, and a direction time. The direction time applies both as a hold after the last step in the old direction and as a setup before the first step in the new one.

All three times are 5-bit fields counted in units of one time base. The time base is `TICK_DIV` clocks, which gives 1.6 µs at the default 64 with a 40 MHz clock. A zero field counts as one unit, and the largest field is 31 units. With one unit of high time and one of space, the fastest step rate is one step per 2·`TICK_DIV` clocks, which is 312.5 kHz at the defaults. The timing inputs are meant to be wired in common to every channel instance.

A signed position counter follows every emitted step. The host copies it into a feedback register with a separate strobe, so latching feedback does not depend on velocity writes.

Top module: `step_pulse_gen`

## Requirements
- R1: While `rst_n` is low and after its release, `step_o` and `dir_o` are 0 and `pos_o` is 0.
- R2: On every clock the absolute value of the stored velocity is added to an `ACC_W`-bit accumulator, and each carry out requests one step. With `ACC_W`=32 and a velocity of 2^26, the steps rise exactly 64 clocks apart when the timing fields allow it.
- R3: Every step pulse stays high for exactly L·`TICK_DIV` clocks, where L is `step_len_i`, and a value of 0 acts as 1.
- R4: Between two steps in the same direction, `step_o` stays low for at least S·`TICK_DIV` clocks, where S is `step_space_i` and 0 acts as 1. If a request is waiting, the next step rises exactly when that space ends, so with L=S=1 the period is 2·`TICK_DIV` clocks.
- R5: A carry that arrives during an enforced interval is held, not dropped, and is emitted as soon as the interval ends. Carries that arrive while one is already held merge into it.
- R6: `dir_o` is 1 for a negative velocity and 0 otherwise. It changes only while `step_o` is low, and at least T·`TICK_DIV` clocks after the space that follows the last step, where T is `dir_time_i` and 0 acts as 1. The first step in the new direction rises exactly T·`TICK_DIV` clocks after `dir_o` changes.
- R7: An internal signed counter of `POS_W` bits changes on the clock where `step_o` rises: it goes up by 1 when `dir_o` is 0 and down by 1 when `dir_o` is 1.
- R8: `pos_o` takes the counter value only on a clock edge where `pos_latch_i` is 1. Otherwise it holds its value, while steps are being emitted and across velocity writes.
- R9: `vel_i` is stored only on a clock edge where `vel_we` is 1. A change of `vel_i` without `vel_we` has no effect on the step rate.
- R10: A timing field of 31, its largest value, gives 31·`TICK_DIV` clocks; with `step_len_i`=31 the pulse is high for 31·`TICK_DIV` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vel_we | input | 1 | Write enable for the velocity |
| vel_i | input | ACC_W | Signed velocity, added to the accumulator per clock |
| step_len_i | input | TW | Minimum step high time in time-base units |
| step_space_i | input | TW | Minimum low time between steps in units |
| dir_time_i | input | TW | Direction hold and setup time in units |
| pos_latch_i | input | 1 | Copies the position counter to `pos_o` |
| step_o | output | 1 | Step pulse |
| dir_o | output | 1 | Direction, 1 for negative motion |
| pos_o | output | POS_W | Latched signed step position |

## Verification
Suppose the interval timer keeps a stale count, or it restarts at the wrong time. The first step pulse or space after the fault would then have the wrong length in clocks. The bench measures those lengths exactly, so it sees the error within one step period. A lost pending request shows up as a longer rise-to-rise period in the pending test. A wrong or early direction decision shows up as the wrong gap between the `dir_o` edge and the next rising step. A counter that moves the wrong way, or misses steps, differs from the step count the bench observes. That difference appears at the next latch strobe and stays visible at `pos_o` until the strobe after it.

// File: rtl/stepgen_pkg.sv
package stepgen_pkg;

    // Width of each timing field, in time-base units
    parameter int unsigned STEP_TIME_W = 5;

    // Sequencer states
    typedef enum logic [2:0] {
        SEQ_IDLE  = 3'd0,
        SEQ_HOLD  = 3'd1,
        SEQ_SETUP = 3'd2,
        SEQ_HIGH  = 3'd3,
        SEQ_SPACE = 3'd4
    } seq_state_e;

endpackage

// File: rtl/stepgen_accum.sv
module stepgen_accum #(
    parameter int unsigned ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vel_we,
    input  logic [ACC_W-1:0] vel_i,
    output logic             carry_o,
    output logic             want_neg_o
);
    typedef struct packed {
        logic [ACC_W-1:0] vel;
        logic [ACC_W-1:0] acc;
        logic             carry;
    } accum_t;

    accum_t acc_d, acc_q;
    logic [ACC_W-1:0] mag;

    always_comb begin
        acc_d = acc_q;
        mag   = acc_q.vel[ACC_W-1] ? (~acc_q.vel + 1'b1) : acc_q.vel;
        if (vel_we) begin
            acc_d.vel = vel_i;
        end
        {acc_d.carry, acc_d.acc} = {1'b0, acc_q.acc} + {1'b0, mag};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign carry_o    = acc_q.carry;
    assign want_neg_o = acc_q.vel[ACC_W-1];

endmodule

// File: rtl/stepgen_timer.sv
module stepgen_timer #(
    parameter int unsigned TICK_DIV = 64,
    parameter int unsigned TW       = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    input  logic [TW-1:0] units_i,
    output logic          done_o
);
    localparam int unsigned DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [TW-1:0]    units;
    } timer_t;

    timer_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (restart_i) begin
            tm_d.cnt   = '0;
            tm_d.units = '0;
        end else if (tm_q.cnt == DIV_LAST) begin
            tm_d.cnt   = '0;
            tm_d.units = tm_q.units + 1'b1;
        end else begin
            tm_d.cnt = tm_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tm_q <= '0;
        end else begin
            tm_q <= tm_d;
        end
    end

    // Last clock of the requested number of units
    assign done_o = (tm_q.cnt == DIV_LAST) && (tm_q.units == (units_i - 1'b1));

endmodule

// File: rtl/stepgen_seq.sv
module stepgen_seq
    import stepgen_pkg::*;
#(
    parameter int unsigned TW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          carry_i,
    input  logic          want_neg_i,
    input  logic [TW-1:0] len_i,
    input  logic [TW-1:0] space_i,
    input  logic [TW-1:0] dirt_i,
    input  logic          done_i,
    output logic          restart_o,
    output logic [TW-1:0] units_o,
    output logic          start_o,
    output logic          step_o,
    output logic          dir_o
);
    typedef struct packed {
        seq_state_e state;
        logic       dir;
        logic       pend;
    } seq_t;

    seq_t sq_d, sq_q;
    logic launch;

    function automatic logic [TW-1:0] at_least_one(input logic [TW-1:0] v);
        return (v == '0) ? TW'(1) : v;
    endfunction

    always_comb begin
        sq_d    = sq_q;
        start_o = 1'b0;
        launch  = 1'b0;
        sq_d.pend = sq_q.pend | carry_i;
        unique case (sq_q.state)
            SEQ_IDLE:  launch = 1'b1;
            SEQ_HIGH:  if (done_i) sq_d.state = SEQ_SPACE;
            SEQ_SPACE: if (done_i) launch = 1'b1;
            SEQ_HOLD: begin
                if (done_i) begin
                    sq_d.state = SEQ_SETUP;
                    sq_d.dir   = want_neg_i;
                end
            end
            SEQ_SETUP: if (done_i) launch = 1'b1;
            default:   sq_d.state = SEQ_IDLE;
        endcase
        if (launch) begin
            if (!sq_q.pend) begin
                sq_d.state = SEQ_IDLE;
            end else if (want_neg_i == sq_q.dir) begin
                sq_d.state = SEQ_HIGH;
                sq_d.pend  = carry_i;
                start_o    = 1'b1;
            end else begin
                sq_d.state = SEQ_HOLD;
            end
        end
    end

    always_comb begin
        unique case (sq_q.state)
            SEQ_HIGH:  units_o = at_least_one(len_i);
            SEQ_SPACE: units_o = at_least_one(space_i);
            default:   units_o = at_least_one(dirt_i);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q <= '{state: SEQ_IDLE, dir: 1'b0, pend: 1'b0};
        end else begin
            sq_q <= sq_d;
        end
    end

    assign restart_o = (sq_d.state != sq_q.state);
    assign step_o    = (sq_q.state == SEQ_HIGH);
    assign dir_o     = sq_q.dir;

endmodule

// File: rtl/stepgen_pos.sv
module stepgen_pos #(
    parameter int unsigned POS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             neg_i,
    input  logic             latch_i,
    output logic [POS_W-1:0] pos_o
);
    typedef struct packed {
        logic [POS_W-1:0] cnt;
        logic [POS_W-1:0] fb;
    } pos_t;

    pos_t ps_d, ps_q;

    always_comb begin
        ps_d = ps_q;
        if (start_i) begin
            ps_d.cnt = neg_i ? (ps_q.cnt - 1'b1) : (ps_q.cnt + 1'b1);
        end
        if (latch_i) begin
            ps_d.fb = ps_q.cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else begin
            ps_q <= ps_d;
        end
    end

    assign pos_o = ps_q.fb;

endmodule

// File: rtl/step_pulse_gen.sv
module step_pulse_gen
    import stepgen_pkg::*;
#(
    parameter int unsigned ACC_W    = 32,
    parameter int unsigned POS_W    = 32,
    parameter int unsigned TW       = STEP_TIME_W,
    parameter int unsigned TICK_DIV = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vel_we,
    input  logic [ACC_W-1:0] vel_i,
    input  logic [TW-1:0]    step_len_i,
    input  logic [TW-1:0]    step_space_i,
    input  logic [TW-1:0]    dir_time_i,
    input  logic             pos_latch_i,
    output logic             step_o,
    output logic             dir_o,
    output logic [POS_W-1:0] pos_o
);
    logic          carry;
    logic          want_neg;
    logic          restart;
    logic          done;
    logic          start;
    logic [TW-1:0] units;

    stepgen_accum #(.ACC_W(ACC_W)) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .vel_we     (vel_we),
        .vel_i      (vel_i),
        .carry_o    (carry),
        .want_neg_o (want_neg)
    );

    stepgen_timer #(.TICK_DIV(TICK_DIV), .TW(TW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .units_i   (units),
        .done_o    (done)
    );

    stepgen_seq #(.TW(TW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .carry_i    (carry),
        .want_neg_i (want_neg),
        .len_i      (step_len_i),
        .space_i    (step_space_i),
        .dirt_i     (dir_time_i),
        .done_i     (done),
        .restart_o  (restart),
        .units_o    (units),
        .start_o    (start),
        .step_o     (step_o),
        .dir_o      (dir_o)
    );

    stepgen_pos #(.POS_W(POS_W)) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .neg_i   (dir_o),
        .latch_i (pos_latch_i),
        .pos_o   (pos_o)
    );

endmodule

// File: rtl/step_pulse_gen_chk.sv
module step_pulse_gen_chk #(
    parameter int unsigned POS_W    = 32,
    parameter int unsigned TW       = 5,
    parameter int unsigned TICK_DIV = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             step_o,
    input logic             dir_o,
    input logic [POS_W-1:0] pos_o,
    input logic             pos_latch_i,
    input logic [TW-1:0]    step_len_i,
    input logic [TW-1:0]    step_space_i,
    input logic [TW-1:0]    dir_time_i
);
    localparam int unsigned CW = 16;

    logic [CW-1:0] hi_cnt, lo_cnt, dir_age;
    logic          dir_prev;

    function automatic logic [CW-1:0] clocks_of(input logic [TW-1:0] v);
        return CW'(((v == '0) ? 1 : int'(v)) * TICK_DIV);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt   <= '0;
            lo_cnt   <= '1;
            dir_age  <= '1;
            dir_prev <= 1'b0;
        end else begin
            hi_cnt   <= step_o ? hi_cnt + 1'b1 : '0;
            lo_cnt   <= step_o ? '0 : ((lo_cnt == '1) ? lo_cnt : lo_cnt + 1'b1);
            dir_prev <= dir_o;
            if (dir_o != dir_prev) begin
                dir_age <= CW'(1);
            end else if (dir_age != '1) begin
                dir_age <= dir_age + 1'b1;
            end
        end
    end

    // R3
    high_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(step_o) |-> hi_cnt >= clocks_of(step_len_i));

    // R4
    space_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(step_o) |-> lo_cnt >= clocks_of(step_space_i));

    // R6
    dir_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(step_o) |-> dir_age >= clocks_of(dir_time_i));

    // R6
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dir_o) |-> (!step_o && lo_cnt >= clocks_of(dir_time_i)));

    // R8
    fb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pos_latch_i) |-> $stable(pos_o));

endmodule

bind step_pulse_gen step_pulse_gen_chk #(
    .POS_W    (POS_W),
    .TW       (TW),
    .TICK_DIV (TICK_DIV)
) u_chk (.*);

// File: tb/step_pulse_gen_test.sv
module step_pulse_gen_test;
    localparam int D = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vel_we = 1'b0;
    logic [31:0] vel_i = '0;
    logic [4:0]  step_len_i = 5'd1;
    logic [4:0]  step_space_i = 5'd1;
    logic [4:0]  dir_time_i = 5'd1;
    logic        pos_latch_i = 1'b0;
    logic        step_o;
    logic        dir_o;
    logic [31:0] pos_o;

    int checks = 0;
    int failures = 0;
    int pos_model = 0;
    logic mon_prev = 1'b0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    step_pulse_gen #(.TICK_DIV(D)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .vel_we       (vel_we),
        .vel_i        (vel_i),
        .step_len_i   (step_len_i),
        .step_space_i (step_space_i),
        .dir_time_i   (dir_time_i),
        .pos_latch_i  (pos_latch_i),
        .step_o       (step_o),
        .dir_o        (dir_o),
        .pos_o        (pos_o)
    );

    // Step counter kept from the outputs alone
    always begin
        @(posedge clk);
        #2;
        if (rst_n && step_o && !mon_prev) pos_model += dir_o ? -1 : 1;
        mon_prev = step_o;
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check_eq(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_ge(string req, longint act, longint lim);
        checks++;
        if (act < lim) begin
            failures++;
            $display("FAIL %s actual=%0d expected>=%0d", req, act, lim);
        end
    endtask

    task automatic set_vel(logic [31:0] v);
        vel_i  = v;
        vel_we = 1'b1;
        tick();
        vel_we = 1'b0;
    endtask

    task automatic latch_pos();
        pos_latch_i = 1'b1;
        tick();
        pos_latch_i = 1'b0;
    endtask

    task automatic wait_rise();
        logic prev;
        for (int g = 0; g < 5000; g++) begin
            prev = step_o;
            tick();
            if (!prev && step_o) break;
        end
    endtask

    // Starts on the first high sample, returns on the first low sample
    task automatic meas_high(output int n);
        n = 1;
        for (int g = 0; g < 5000; g++) begin
            tick();
            if (!step_o) break;
            n++;
        end
    endtask

    // Starts on the first low sample, returns on the next high sample
    task automatic meas_low(output int n);
        n = 1;
        for (int g = 0; g < 5000; g++) begin
            tick();
            if (step_o) break;
            n++;
        end
    endtask

    task automatic t_reset();
        check_eq("R1 step during reset", step_o, 0);
        check_eq("R1 dir during reset", dir_o, 0);
        check_eq("R1 pos during reset", pos_o, 0);
        rst_n = 1'b1;
        repeat (3) tick();
        check_eq("R1 step after reset", step_o, 0);
        check_eq("R1 pos after reset", pos_o, 0);
    endtask

    task automatic t_widths();
        int h, l;
        step_len_i = 5'd3; step_space_i = 5'd2; dir_time_i = 5'd1;
        set_vel(32'h4000_0000);
        wait_rise(); wait_rise();
        meas_high(h); meas_low(l);
        check_eq("R3 high time len=3", h, 3 * D);
        check_eq("R4 space len=2 pending", l, 2 * D);
        step_len_i = 5'd0; step_space_i = 5'd0;
        wait_rise(); wait_rise();
        meas_high(h); meas_low(l);
        check_eq("R3 zero len acts as one", h, D);
        check_eq("R4 zero space acts as one", l, D);
        step_len_i = 5'd1; step_space_i = 5'd1;
        wait_rise(); wait_rise();
        meas_high(h); meas_low(l);
        check_eq("R4 fastest period", h + l, 2 * D);
        step_len_i = 5'd31;
        wait_rise(); wait_rise();
        meas_high(h);
        check_eq("R10 max length field", h, 31 * D);
    endtask

    task automatic t_pending();
        int h, l;
        step_len_i = 5'd10; step_space_i = 5'd10;
        set_vel(32'h0400_0000);
        wait_rise(); wait_rise();
        for (int k = 0; k < 2; k++) begin
            meas_high(h); meas_low(l);
            check_eq("R5 held request emitted at space end", h + l, 20 * D);
        end
    endtask

    task automatic t_rate();
        int h, l;
        step_len_i = 5'd1; step_space_i = 5'd1;
        set_vel(32'h0400_0000);
        wait_rise(); wait_rise();
        meas_high(h); meas_low(l);
        check_eq("R2 period from accumulator", h + l, 64);
        vel_i = 32'h4000_0000;
        meas_high(h); meas_low(l);
        check_eq("R9 vel_i without write ignored", h + l, 64);
        meas_high(h); meas_low(l);
        check_eq("R2 period repeat", h + l, 64);
    endtask

    task automatic t_dir();
        int lowrun, n;
        step_len_i = 5'd2; step_space_i = 5'd2; dir_time_i = 5'd3;
        set_vel(32'h4000_0000);
        wait_rise(); wait_rise();
        check_eq("R6 positive dir level", dir_o, 0);
        set_vel(32'hC000_0000);
        lowrun = 0;
        for (int g = 0; g < 5000 && !dir_o; g++) begin
            tick();
            lowrun = step_o ? 0 : lowrun + 1;
        end
        check_eq("R6 negative dir level", dir_o, 1);
        check_ge("R6 hold after space", lowrun, (2 + 3) * D);
        n = 0;
        for (int g = 0; g < 5000; g++) begin
            tick();
            n++;
            if (step_o) break;
        end
        check_eq("R6 setup before first step", n, 3 * D);
    endtask

    task automatic t_pos();
        int p1, p2;
        set_vel(32'hFFFF_FFFF);
        repeat (600) tick();
        latch_pos();
        check_eq("R7 count matches observed steps", $signed(pos_o), pos_model);
        p1 = $signed(pos_o);
        set_vel(32'hC000_0000);
        for (int k = 0; k < 10; k++) wait_rise();
        set_vel(32'hFFFF_FFFF);
        repeat (600) tick();
        latch_pos();
        check_eq("R7 count after reverse steps", $signed(pos_o), pos_model);
        check_ge("R7 reverse steps decrement", p1 - $signed(pos_o), 10);
        p2 = $signed(pos_o);
        set_vel(32'h4000_0000);
        repeat (300) tick();
        check_eq("R8 no strobe holds feedback", $signed(pos_o), p2);
        set_vel(32'h0000_0001);
        repeat (600) tick();
        check_eq("R8 no strobe after writes", $signed(pos_o), p2);
        latch_pos();
        check_eq("R8 strobe loads count", $signed(pos_o), pos_model);
    endtask

    initial begin
        repeat (5) tick();
        t_reset();
        t_widths();
        t_pending();
        t_rate();
        t_dir();
        t_pos();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule